// File: doc/BRIEF.md
# Dual-Side Parallel I/O Adapter

This block gives a processor two 8-bit parallel ports, called side A and side B. Each side has three registers: a direction register, an output latch and a control register. The CPU reaches them through a small bus with a chip select, write and read strobes, and a register address. Every line of a port can be set on its own to be an input or an output. A read of the data address returns the latched value on output lines and the live pin level on input lines.

Each side also has two handshake lines. Handshake line 1 is always an input. It has a programmable active edge, and that edge sets a sticky flag that can raise the side's active-low interrupt. Handshake line 2 is an input with its own edge, flag and interrupt enable, or it is a level output driven from a control bit. Both handshake inputs pass through a two-flop synchronizer before their edges are detected. A read of a side's data register acknowledges both of that side's flags.

Only the two lowest address bits are decoded, so the four registers repeat across the whole 32-byte window.

Top module: `pio_adapter`

## Requirements
- R1: After reset every register holds zero. All port and line-2 output enables are low, both interrupt outputs are high, and every register reads 0x00.
- R2: Register address bits [1:0] select the register: 0 is side A data, 1 is side A control, 2 is side B data and 3 is side B control. The upper address bits are ignored, so the map repeats every 4 bytes across the 32-byte window.
- R3: Control bit 2 decides what the data address reaches, for both reads and writes. When it is 0 the data address reaches the direction register. When it is 1 it reaches the output latch and the pins.
- R4: A direction bit of 1 makes that line an output: its enable is high and it drives the latch bit. A data read returns the latch bit for output lines and the pin level for input lines.
- R5: Control bit 1 selects the active edge of handshake line 1 (0 = falling, 1 = rising). An active edge sets control bit 7. The flag is visible, and the interrupt output can go low, after the third rising clock edge that follows the pin change. An inactive edge sets nothing.
- R6: Control bit 0 enables the interrupt for the line-1 flag. When bit 0 is 0 the flag still sets, but the interrupt output stays high.
- R7: When control bits 5 and 4 are both 1, handshake line 2 is an output (enable high) and its level equals control bit 3.
- R8: When control bit 5 is 0, line 2 is an input. Bit 4 selects its active edge (0 = falling, 1 = rising), bit 6 is its flag, and bit 3 enables its interrupt. When bits 5:4 are 10, the line is released (enable low) and its flag never sets.
- R9: A read of the data address while control bit 2 is 1 clears both flags of that side. A read of the control register does not clear them. If an active edge arrives in the same cycle as the clearing read, the edge wins.
- R10: Control bits 7 and 6 are read-only. Writes to them are ignored.
- R11: The two sides are independent. Writes to one side and edges on one side change nothing on the other side, and each interrupt output reflects only its own side's flags.
- R12: A write has effect only when chip select is high. Read data is 0x00 unless chip select and the read strobe are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Register address within the 32-byte window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| a_pin_in | input | 8 | Side A pin levels |
| a_pin_out | output | 8 | Side A output latch |
| a_pin_oe | output | 8 | Side A per-line output enable |
| a_hs1 | input | 1 | Side A handshake line 1 |
| a_hs2_in | input | 1 | Side A handshake line 2, input level |
| a_hs2_out | output | 1 | Side A handshake line 2, output level |
| a_hs2_oe | output | 1 | Side A handshake line 2, output enable |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_pin_in | input | 8 | Side B pin levels |
| b_pin_out | output | 8 | Side B output latch |
| b_pin_oe | output | 8 | Side B per-line output enable |
| b_hs1 | input | 1 | Side B handshake line 1 |
| b_hs2_in | input | 1 | Side B handshake line 2, input level |
| b_hs2_out | output | 1 | Side B handshake line 2, output level |
| b_hs2_oe | output | 1 | Side B handshake line 2, output enable |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
Read data is combinational, so the bench samples it within the same cycle that the read strobe is asserted. Register writes and flag clears take effect at the next rising edge, and the bench checks them on the next access. A handshake edge needs three rising clock edges before its flag or interrupt appears. The bench therefore changes the pin on a falling edge, confirms that the interrupt is still high two cycles later, and confirms that it is low on the third cycle. Port enables, port outputs and line-2 outputs change one edge after the write, and the bench samples them on the falling edge that follows.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // Register select codes (address bits [1:0])
  typedef enum logic [1:0] {
    SEL_A_DATA = 2'd0,
    SEL_A_CTRL = 2'd1,
    SEL_B_DATA = 2'd2,
    SEL_B_CTRL = 2'd3
  } reg_sel_e;

  // Control register bit positions
  localparam int CB_IEN1   = 0;
  localparam int CB_EDGE1  = 1;
  localparam int CB_DSEL   = 2;
  localparam int CB_L2LVL  = 3;
  localparam int CB_L2EDGE = 4;
  localparam int CB_L2DIR  = 5;
  localparam int CB_FLAG2  = 6;
  localparam int CB_FLAG1  = 7;
  localparam int CTRL_RW_W = 6;
endpackage

// File: rtl/pio_edge_det.sv
module pio_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              cur;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = pin;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], pin};
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_comb begin
    prev_d = cur;
    hit    = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/pio_side.sv
module pio_side
  import pio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic              wr_ctrl,
  input  logic              rd_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pin_in,
  input  logic              hs1,
  input  logic              hs2_in,
  output logic [DATA_W-1:0] port_out,
  output logic [DATA_W-1:0] port_oe,
  output logic              hs2_out,
  output logic              hs2_oe,
  output logic              irq_n,
  output logic [DATA_W-1:0] data_rd_val,
  output logic [7:0]        ctrl_rd_val
);
  logic [DATA_W-1:0]    ddr_q, ddr_d, out_q, out_d;
  logic [CTRL_RW_W-1:0] ctrl_q, ctrl_d;
  logic                 flag1_q, flag1_d, flag2_q, flag2_d;
  logic                 hit1, hit2_raw, hit2, clr;
  logic                 ddr_en, out_en;

  pio_edge_det #(.STAGES(SYNC_STAGES)) u_hs1 (
    .clk(clk), .rst_n(rst_n), .pin(hs1),
    .rise_sel(ctrl_q[CB_EDGE1]), .hit(hit1)
  );

  pio_edge_det #(.STAGES(SYNC_STAGES)) u_hs2 (
    .clk(clk), .rst_n(rst_n), .pin(hs2_in),
    .rise_sel(ctrl_q[CB_L2EDGE]), .hit(hit2_raw)
  );

  always_comb begin
    hit2    = hit2_raw & ~ctrl_q[CB_L2DIR];
    clr     = rd_data & ctrl_q[CB_DSEL];
    ddr_en  = wr_data & ~ctrl_q[CB_DSEL];
    out_en  = wr_data &  ctrl_q[CB_DSEL];
    ddr_d   = ddr_en  ? wdata : ddr_q;
    out_d   = out_en  ? wdata : out_q;
    ctrl_d  = wr_ctrl ? wdata[CTRL_RW_W-1:0] : ctrl_q;
    flag1_d = hit1 | (flag1_q & ~clr);
    flag2_d = hit2 | (flag2_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ddr_q   <= '0;
      out_q   <= '0;
      ctrl_q  <= '0;
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
    end else begin
      ddr_q   <= ddr_d;
      out_q   <= out_d;
      ctrl_q  <= ctrl_d;
      flag1_q <= flag1_d;
      flag2_q <= flag2_d;
    end
  end

  always_comb begin
    port_out    = out_q;
    port_oe     = ddr_q;
    hs2_oe      = ctrl_q[CB_L2DIR] & ctrl_q[CB_L2EDGE];
    hs2_out     = hs2_oe & ctrl_q[CB_L2LVL];
    irq_n       = ~((flag1_q & ctrl_q[CB_IEN1]) |
                    (flag2_q & ctrl_q[CB_L2LVL] & ~ctrl_q[CB_L2DIR]));
    data_rd_val = ctrl_q[CB_DSEL] ? ((out_q & ddr_q) | (pin_in & ~ddr_q)) : ddr_q;
    ctrl_rd_val = {flag1_q, flag2_q, ctrl_q};
  end

  // R5
  flag1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> flag1_q);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit1 && !hit2) |=> (!flag1_q && !flag2_q));

  // R3
  ddr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !ctrl_q[CB_DSEL]) |=> (port_oe == $past(wdata)));

  // R7
  line2_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[5:4] == 2'b11) |=> (hs2_oe && hs2_out == $past(wdata[3])));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag1_q || flag2_q));

  // R8
  line2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_L2DIR] && !flag2_q) |=> !flag2_q);

  // R10
  flag1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit1 && !clr) |=> $stable(flag1_q));
endmodule

// File: rtl/pio_adapter.sv
module pio_adapter
  import pio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] a_pin_in,
  output logic [DATA_W-1:0] a_pin_out,
  output logic [DATA_W-1:0] a_pin_oe,
  input  logic              a_hs1,
  input  logic              a_hs2_in,
  output logic              a_hs2_out,
  output logic              a_hs2_oe,
  output logic              a_irq_n,
  input  logic [DATA_W-1:0] b_pin_in,
  output logic [DATA_W-1:0] b_pin_out,
  output logic [DATA_W-1:0] b_pin_oe,
  input  logic              b_hs1,
  input  logic              b_hs2_in,
  output logic              b_hs2_out,
  output logic              b_hs2_oe,
  output logic              b_irq_n
);
  localparam int NSIDES = 2;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  reg_sel_e   sel;
  logic       wr_go, rd_go;
  logic       addr_unused;

  assign sel         = reg_sel_e'(addr[1:0]);
  assign addr_unused = ^addr[ADDR_W-1:2];
  assign wr_go       = cs & wr_en;
  assign rd_go       = cs & rd_en;

  logic [DATA_W-1:0] pin_in_s [NSIDES];
  logic [DATA_W-1:0] pin_out_s[NSIDES];
  logic [DATA_W-1:0] pin_oe_s [NSIDES];
  logic [DATA_W-1:0] data_rd_s[NSIDES];
  logic [7:0]        ctrl_rd_s[NSIDES];
  logic [NSIDES-1:0] hs1_s, hs2_in_s, hs2_out_s, hs2_oe_s, irq_n_s;

  assign pin_in_s[0] = a_pin_in;
  assign pin_in_s[1] = b_pin_in;
  assign hs1_s       = {b_hs1, a_hs1};
  assign hs2_in_s    = {b_hs2_in, a_hs2_in};

  generate
    for (genvar s = 0; s < NSIDES; s++) begin : g_side
      logic hit_side, sel_data, sel_ctrl;
      assign hit_side = (addr[1] == s[0]);
      assign sel_data = hit_side & ~addr[0];
      assign sel_ctrl = hit_side &  addr[0];

      pio_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_side (
        .clk        (clk),
        .rst_n      (rst_i_n),
        .wr_data    (wr_go & sel_data),
        .wr_ctrl    (wr_go & sel_ctrl),
        .rd_data    (rd_go & sel_data),
        .wdata      (wdata),
        .pin_in     (pin_in_s[s]),
        .hs1        (hs1_s[s]),
        .hs2_in     (hs2_in_s[s]),
        .port_out   (pin_out_s[s]),
        .port_oe    (pin_oe_s[s]),
        .hs2_out    (hs2_out_s[s]),
        .hs2_oe     (hs2_oe_s[s]),
        .irq_n      (irq_n_s[s]),
        .data_rd_val(data_rd_s[s]),
        .ctrl_rd_val(ctrl_rd_s[s])
      );
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rd_go) begin
      unique case (sel)
        SEL_A_DATA: rdata = data_rd_s[0];
        SEL_A_CTRL: rdata = DATA_W'(ctrl_rd_s[0]);
        SEL_B_DATA: rdata = data_rd_s[1];
        SEL_B_CTRL: rdata = DATA_W'(ctrl_rd_s[1]);
        default:    rdata = '0;
      endcase
    end
  end

  assign a_pin_out = pin_out_s[0];
  assign a_pin_oe  = pin_oe_s[0];
  assign a_hs2_out = hs2_out_s[0];
  assign a_hs2_oe  = hs2_oe_s[0];
  assign a_irq_n   = irq_n_s[0];
  assign b_pin_out = pin_out_s[1];
  assign b_pin_oe  = pin_oe_s[1];
  assign b_hs2_out = hs2_out_s[1];
  assign b_hs2_oe  = hs2_oe_s[1];
  assign b_irq_n   = irq_n_s[1];

  // R12
  no_write_unselected_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!cs && sel == SEL_A_CTRL) |=> $stable(ctrl_rd_s[0][5:0]));

  // R11
  side_b_isolated_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_go && !addr[1]) |=> $stable(pin_oe_s[1]));
endmodule

// File: tb/pio_adapter_test.sv
module pio_adapter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, wr_en, rd_en;
  logic [4:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] a_pin_in, a_pin_out, a_pin_oe, b_pin_in, b_pin_out, b_pin_oe;
  logic       a_hs1, a_hs2_in, a_hs2_out, a_hs2_oe, a_irq_n;
  logic       b_hs1, b_hs2_in, b_hs2_out, b_hs2_oe, b_irq_n;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pio_adapter uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe),
    .a_hs1(a_hs1), .a_hs2_in(a_hs2_in), .a_hs2_out(a_hs2_out),
    .a_hs2_oe(a_hs2_oe), .a_irq_n(a_irq_n),
    .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
    .b_hs1(b_hs1), .b_hs2_in(b_hs2_in), .b_hs2_out(b_hs2_out),
    .b_hs2_oe(b_hs2_oe), .b_irq_n(b_irq_n)
  );

  typedef struct packed {
    logic       wr;
    logic [4:0] adr;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 5'h00, 8'hF0, 4'd3},  // R3 write direction A
    '{1'b0, 5'h00, 8'hF0, 4'd3},  // R3 read direction A
    '{1'b1, 5'h01, 8'h04, 4'd3},  // R3 select data
    '{1'b1, 5'h00, 8'h5A, 4'd3},  // R3 write latch A
    '{1'b0, 5'h00, 8'h55, 4'd4},  // R4 mix latch and pins
    '{1'b0, 5'h01, 8'h04, 4'd10}, // R10
    '{1'b1, 5'h01, 8'hC4, 4'd10}, // R10 try flag bits
    '{1'b0, 5'h01, 8'h04, 4'd10}, // R10
    '{1'b0, 5'h1D, 8'h04, 4'd2},  // R2 mirror
    '{1'b1, 5'h12, 8'h0F, 4'd2},  // R2 mirror write B dir
    '{1'b0, 5'h02, 8'h0F, 4'd2},  // R2
    '{1'b1, 5'h03, 8'h04, 4'd3},  // R3
    '{1'b1, 5'h0E, 8'h99, 4'd2},  // R2 mirror write B latch
    '{1'b0, 5'h02, 8'h39, 4'd4},  // R4
    '{1'b0, 5'h00, 8'h55, 4'd11}, // R11 side A untouched
    '{1'b0, 5'h1C, 8'h55, 4'd2}   // R2
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    cs = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    a_pin_in = 8'hA5; b_pin_in = 8'h3C;
    a_hs1 = 0; a_hs2_in = 0; b_hs1 = 0; b_hs2_in = 0;
    do_reset();

    // R1 reset state
    check("R1 a_oe", a_pin_oe, 8'h00);
    check("R1 b_oe", b_pin_oe, 8'h00);
    check("R1 irq", {6'd0, a_irq_n, b_irq_n}, 8'h03);
    check("R1 hs2_oe", {6'd0, a_hs2_oe, b_hs2_oe}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd(5'(i), r);
      check("R1 reg", r, 8'h00);
    end

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) wr(VECS[i].adr, VECS[i].val);
      else begin
        rd(VECS[i].adr, r);
        tests++;
        if (r !== VECS[i].val) begin
          fails++;
          $display("FAIL R%0d vec %0d actual=%02h expected=%02h",
                   VECS[i].req, i, r, VECS[i].val);
        end
      end
    end
    // R4 pins driven
    check("R4 a_oe", a_pin_oe, 8'hF0);
    check("R4 a_out", a_pin_out, 8'h5A);
    check("R4 b_oe", b_pin_oe, 8'h0F);

    // R5 / R6 falling edge with interrupt enabled
    wr(5'h01, 8'h05);
    @(negedge clk); a_hs1 = 1'b1;
    repeat (3) @(negedge clk);
    rd(5'h01, r);
    check("R5 inactive edge", r, 8'h05);
    @(negedge clk); a_hs1 = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 latency irq still high", {7'd0, a_irq_n}, 8'h01);
    @(negedge clk);
    check("R5 irq after 3 edges", {7'd0, a_irq_n}, 8'h00);
    check("R11 b irq", {7'd0, b_irq_n}, 8'h01);
    rd(5'h01, r);
    check("R5 flag1", r, 8'h85);
    rd(5'h01, r);
    check("R9 ctrl read keeps flag", r, 8'h85);
    rd(5'h00, r);
    rd(5'h01, r);
    check("R9 data read clears", r, 8'h05);
    check("R9 irq released", {7'd0, a_irq_n}, 8'h01);

    // R6 disabled interrupt, rising edge
    wr(5'h01, 8'h06);
    @(negedge clk); a_hs1 = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 irq masked", {7'd0, a_irq_n}, 8'h01);
    rd(5'h01, r);
    check("R6 flag set masked", r, 8'h86);
    rd(5'h00, r);

    // R7 line 2 level output on B
    wr(5'h03, 8'h3C);
    @(negedge clk);
    check("R7 out high", {6'd0, b_hs2_oe, b_hs2_out}, 8'h03);
    wr(5'h03, 8'h34);
    @(negedge clk);
    check("R7 out low", {6'd0, b_hs2_oe, b_hs2_out}, 8'h02);

    // R8 line 2 input on A, rising edge, enabled
    wr(5'h01, 8'h1C);
    @(negedge clk); a_hs2_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 irq line2", {7'd0, a_irq_n}, 8'h00);
    rd(5'h01, r);
    check("R8 flag2", r, 8'h5C);
    rd(5'h00, r);
    rd(5'h01, r);
    check("R9 flag2 cleared", r, 8'h1C);

    // R8 mode 10 released, no flag
    wr(5'h01, 8'h24);
    @(negedge clk);
    check("R8 released oe", {7'd0, a_hs2_oe}, 8'h00);
    a_hs2_in = 1'b0;
    repeat (4) @(negedge clk);
    a_hs2_in = 1'b1;
    repeat (4) @(negedge clk);
    rd(5'h01, r);
    check("R8 no flag in mode 10", r, 8'h24);

    // R12 unselected write and idle read data
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b1; addr = 5'h01; wdata = 8'h00;
    #1 check("R12 idle rdata", rdata, 8'h00);
    @(negedge clk); wr_en = 1'b0;
    rd(5'h01, r);
    check("R12 write ignored", r, 8'h24);

    // R1 reset again
    do_reset();
    check("R1 a_oe again", a_pin_oe, 8'h00);
    check("R1 irq again", {7'd0, a_irq_n}, 8'h01);
    rd(5'h01, r);
    check("R1 ctrl cleared", r, 8'h00);
    rd(5'h00, r);
    check("R1 dir cleared", r, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule